// File: doc/BRIEF.md
# Transmit Queue Status Tracker

This block follows the state of a small circular transmit queue in a CAN-style controller and presents it as one 16-bit status word. Software posts messages with an enqueue strobe. The protocol engine reports the end of each transmission, either as a normal completion or as an abort. It can qualify that report with a lost-arbitration or bus-error indication, and it can also signal that the attempts for a message have been used up. A queue reset returns the queue to its empty state in a single cycle.

The status word carries four groups of bits:
- the zero-based slot of the message that goes out next;
- an empty flag and a not-full flag;
- the outcome of the most recently finished transmission, held until the next one finishes;
- a sticky attempts-exhausted flag, which hardware sets and software clears by writing a one to its bit.

The message bodies are stored elsewhere. This block counts occupancy and tracks the read slot only.

Top module: `txq_status_tracker`

## Requirements
- R1: After rst_n is held low through a clock edge, status reads 16'h0005: next index 0, empty (bit 2) 1, not-full (bit 0) 1, and all other bits 0.
- R2: Bits 15:13, bit 3 and bit 1 of status always read 0.
- R3: An accepted enqueue raises occupancy by one, visible one cycle later. Bit 2 is 1 exactly when occupancy is 0, and bit 0 is 1 exactly when occupancy is below DEPTH.
- R4: An enqueue while the queue is full (bit 0 = 0) is ignored. Occupancy and the index stay unchanged.
- R5: A completion (tx_done) or abort (tx_abort) while the queue is not empty advances the index in bits 12:8 by one, modulo DEPTH, and lowers occupancy by one. While the queue is empty, such an event is ignored.
- R6: On an accepted completion or abort, bit 7 takes tx_abort, bit 6 takes tx_lost_arb and bit 5 takes tx_bus_err. At all other times, bits 7:5 hold their value.
- R7: Bit 4 is set one cycle after tx_exhausted. It is cleared by clr_wr with clr_data[4] = 1. A set in the same cycle as a clear wins. q_reset does not affect bit 4.
- R8: q_reset sets the index to 0, occupancy to 0 and bits 7:5 to 0 in one cycle. It overrides an enqueue, completion or abort in the same cycle.
- R9: An enqueue together with an accepted completion on a non-full queue leaves occupancy unchanged and advances the index. On a full queue, the enqueue is refused and the completion still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_req | input | 1 | Software enqueue strobe |
| tx_done | input | 1 | Transmission finished successfully |
| tx_abort | input | 1 | Transmission aborted |
| tx_lost_arb | input | 1 | Qualifier: arbitration was lost |
| tx_bus_err | input | 1 | Qualifier: bus error occurred |
| tx_exhausted | input | 1 | Transmit attempts used up |
| q_reset | input | 1 | Queue reset |
| clr_wr | input | 1 | Status write strobe (write one to clear) |
| clr_data | input | 16 | Status write data |
| status | output | 16 | Status word |

## Verification
Every field of the status word comes straight from a register. Each result of a stimulus applied before edge N is therefore due in the cycle that follows edge N, and nothing lags further behind. The bench applies inputs on the falling edge. It advances its behavioural model on the rising edge and compares all five field groups one time unit later. The same one-cycle rule applies to index wrap, full-queue refusal, outcome latching and the set-versus-clear race.

// File: rtl/txq_pkg.sv
// Package: shared field positions and widths of the transmit queue status word.
// Assumes a 16-bit word whose index field is five bits wide.
package txq_pkg;
    localparam int STATUS_W   = 16;
    localparam int IDX_FLD_W  = 5;
    localparam int IDX_LSB    = 8;
    localparam int ABT_BIT    = 7;
    localparam int LARB_BIT   = 6;
    localparam int BERR_BIT   = 5;
    localparam int EXH_BIT    = 4;
    localparam int EMPTY_BIT  = 2;
    localparam int NFULL_BIT  = 0;

    // Latched outcome of the last finished transmission
    typedef struct packed {
        logic aborted;
        logic lost_arb;
        logic bus_err;
    } tx_outcome_t;
endpackage

// File: rtl/txq_wrap_ctr.sv
// Module: modulo-DEPTH slot counter. It steps on request and returns to zero on clear.
// Assumes DEPTH >= 1 and that W is wide enough to hold DEPTH-1.
module txq_wrap_ctr #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] LAST = W'(DEPTH - 1);

    // Slot register: clear first, then step with wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            value <= '0;
        else if (step)
            value <= (value == LAST) ? '0 : value + 1'b1;
    end
endmodule

// File: rtl/txq_occupancy.sv
// Module: occupancy counter with empty and full flags.
// Assumes push and pop are already gated by the caller (no push while full, no pop while empty).
module txq_occupancy #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic push,
    input  logic pop,
    output logic empty,
    output logic full
);
    logic [CNT_W-1:0] count;

    // Message count: clear wins, then net change of push and pop
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (push && !pop)
            count <= count + 1'b1;
        else if (pop && !push)
            count <= count - 1'b1;
    end

    // Flags decoded from the count
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end
endmodule

// File: rtl/txq_outcome.sv
// Module: holds the outcome of the last finished transmission and the sticky exhausted flag.
// Assumes done_ok pulses only for transmissions that the queue accepts as finished.
module txq_outcome
    import txq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        done_ok,
    input  tx_outcome_t done_info,
    input  logic        exh_set,
    input  logic        exh_clr,
    output tx_outcome_t outcome,
    output logic        exh_flag
);
    // Outcome latch: load on each finished transmission, cleared by queue reset
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            outcome <= '0;
        else if (done_ok)
            outcome <= done_info;
    end

    // Sticky exhausted flag: a hardware set beats a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            exh_flag <= 1'b0;
        else if (exh_set)
            exh_flag <= 1'b1;
        else if (exh_clr)
            exh_flag <= 1'b0;
    end
endmodule

// File: rtl/txq_status_tracker.sv
// Module: top of the transmit queue status tracker. It gates queue events and packs the status word.
// Assumes 1 <= DEPTH <= 32. Events arriving with q_reset are discarded.
module txq_status_tracker
    import txq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enq_req,
    input  logic        tx_done,
    input  logic        tx_abort,
    input  logic        tx_lost_arb,
    input  logic        tx_bus_err,
    input  logic        tx_exhausted,
    input  logic        q_reset,
    input  logic        clr_wr,
    input  logic [15:0] clr_data,
    output logic [15:0] status
);
    logic             empty, full;
    logic             push_ok, pop_ok;
    logic [PTR_W-1:0] rd_slot;
    tx_outcome_t      fin_info, outcome;
    logic             exh_flag;
    logic [IDX_FLD_W-1:0] idx_fld;

    // Event acceptance based on the current occupancy
    always_comb begin
        push_ok  = enq_req && !full && !q_reset;
        pop_ok   = (tx_done || tx_abort) && !empty && !q_reset;
        fin_info = '{aborted: tx_abort, lost_arb: tx_lost_arb, bus_err: tx_bus_err};
    end

    txq_wrap_ctr #(.DEPTH(DEPTH), .W(PTR_W)) u_rd_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (q_reset),
        .step  (pop_ok),
        .value (rd_slot)
    );

    txq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (q_reset),
        .push  (push_ok),
        .pop   (pop_ok),
        .empty (empty),
        .full  (full)
    );

    txq_outcome u_outc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q_reset),
        .done_ok   (pop_ok),
        .done_info (fin_info),
        .exh_set   (tx_exhausted),
        .exh_clr   (clr_wr && clr_data[EXH_BIT]),
        .outcome   (outcome),
        .exh_flag  (exh_flag)
    );

    // Status word packing; unlisted bits stay zero
    always_comb begin
        idx_fld = IDX_FLD_W'(rd_slot);
        status  = '0;
        status[IDX_LSB +: IDX_FLD_W] = idx_fld;
        status[ABT_BIT]   = outcome.aborted;
        status[LARB_BIT]  = outcome.lost_arb;
        status[BERR_BIT]  = outcome.bus_err;
        status[EXH_BIT]   = exh_flag;
        status[EMPTY_BIT] = empty;
        status[NFULL_BIT] = !full;
    end
endmodule

// File: rtl/txq_status_chk.sv
// Module: property checker for txq_status_tracker. It observes ports only.
// Assumes it is attached by the bind statement at the end of this file.
module txq_status_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enq_req,
    input logic        tx_done,
    input logic        tx_abort,
    input logic        tx_exhausted,
    input logic        q_reset,
    input logic        clr_wr,
    input logic [15:0] clr_data,
    input logic [15:0] status
);
    logic fin_ev;
    assign fin_ev = (tx_done || tx_abort) && !status[2];

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:13] == 3'b000 && !status[3] && !status[1]);

    // R3
    empty_implies_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[0]);

    // R4
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_reset && enq_req && !status[0] && !tx_done && !tx_abort)
        |=> (!status[0] && $stable(status[12:8])));

    // R5
    idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_reset && fin_ev) |=>
        (status[12:8] == (($past(status[12:8]) == 5'(DEPTH - 1)) ? 5'd0 : $past(status[12:8]) + 5'd1)));

    // R6
    outcome_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_reset && !fin_ev) |=> $stable(status[7:5]));

    // R7
    exh_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_exhausted |=> status[4]);

    // R7
    exh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_exhausted && clr_wr && clr_data[4]) |=> !status[4]);

    // R8
    qreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_reset |=> (status[12:8] == 5'd0 && status[2] && status[0] && status[7:5] == 3'b000));
endmodule

bind txq_status_tracker txq_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enq_req      (enq_req),
    .tx_done      (tx_done),
    .tx_abort     (tx_abort),
    .tx_exhausted (tx_exhausted),
    .q_reset      (q_reset),
    .clr_wr       (clr_wr),
    .clr_data     (clr_data),
    .status       (status)
);

// File: tb/txq_status_tracker_tb.sv
// Bench: behavioural reference model, compared field by field after every clock.
module txq_status_tracker_tb;
    localparam int DEPTH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_req = 0, tx_done = 0, tx_abort = 0, tx_lost_arb = 0, tx_bus_err = 0;
    logic        tx_exhausted = 0, q_reset = 0, clr_wr = 0;
    logic [15:0] clr_data = '0;
    logic [15:0] status;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // model state
    int m_cnt = 0, m_rd = 0;
    bit m_abt = 0, m_larb = 0, m_berr = 0, m_exh = 0;

    always #2 clk = ~clk;

    txq_status_tracker #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .enq_req(enq_req), .tx_done(tx_done),
        .tx_abort(tx_abort), .tx_lost_arb(tx_lost_arb), .tx_bus_err(tx_bus_err),
        .tx_exhausted(tx_exhausted), .q_reset(q_reset), .clr_wr(clr_wr),
        .clr_data(clr_data), .status(status)
    );

    task automatic chk(input string tag, input string phase, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, phase, act, exp);
        end
    endtask

    task automatic compare(input string phase);
        chk("R2", phase, {status[15:13], status[3], status[1]}, 0);
        chk("R5", phase, status[12:8], m_rd);
        chk("R3", phase, {status[2], status[0]}, {m_cnt == 0, m_cnt < DEPTH});
        chk("R6", phase, status[7:5], {m_abt, m_larb, m_berr});
        chk("R7", phase, status[4], m_exh);
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, compare just after
    task automatic step(input bit e, input bit d, input bit a, input bit l, input bit b,
                        input bit x, input bit qr, input bit cw, input bit c4, input string phase);
        bit comp, acc;
        @(negedge clk);
        enq_req = e; tx_done = d; tx_abort = a; tx_lost_arb = l; tx_bus_err = b;
        tx_exhausted = x; q_reset = qr; clr_wr = cw; clr_data = c4 ? 16'h0010 : 16'hFFEF;
        @(posedge clk);
        if (qr) begin
            m_cnt = 0; m_rd = 0; m_abt = 0; m_larb = 0; m_berr = 0;
        end else begin
            comp = (d || a) && (m_cnt > 0);
            acc  = e && (m_cnt < DEPTH);
            if (comp) begin
                m_rd = (m_rd + 1) % DEPTH;
                m_abt = a; m_larb = l; m_berr = b;
            end
            m_cnt = m_cnt + int'(acc) - int'(comp);
        end
        if (x) m_exh = 1;
        else if (cw && c4) m_exh = 0;
        #1 compare(phase);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0;
        chk("R1", "reset", status, 16'h0005);
        // R3 / R4: fill and overfill
        for (int i = 0; i < DEPTH + 3; i++) step(1,0,0,0,0, 0,0,0,0, (i < DEPTH) ? "R3 fill" : "R4 full");
        // R5 / R6: drain with varied qualifiers, then events while empty
        step(0,1,0,0,0, 0,0,0,0, "R6 ok");
        step(0,0,1,1,0, 0,0,0,0, "R6 abort+arb");
        step(0,1,0,0,1, 0,0,0,0, "R6 berr");
        step(0,0,0,0,0, 0,0,0,0, "R6 hold");
        step(0,0,1,1,1, 0,0,0,0, "R6 all");
        step(0,1,0,0,0, 0,0,0,0, "R5 drain");
        step(0,0,1,1,1, 0,0,0,0, "R5 empty ignore");
        // R5 wrap across several laps
        for (int i = 0; i < 2 * DEPTH + 1; i++) begin
            step(1,0,0,0,0, 0,0,0,0, "R5 wrap");
            step(0,1,0,0,0, 0,0,0,0, "R5 wrap");
        end
        // R9: simultaneous enqueue and completion
        step(1,0,0,0,0, 0,0,0,0, "R9 prep");
        step(1,1,0,0,0, 0,0,0,0, "R9 both");
        for (int i = 0; i < DEPTH; i++) step(1,0,0,0,0, 0,0,0,0, "R9 fill");
        step(1,0,1,0,1, 0,0,0,0, "R9 both full");
        step(1,0,0,0,0, 0,0,0,0, "R9 refill");
        // R7: exhausted flag
        step(0,0,0,0,0, 1,0,0,0, "R7 set");
        step(0,0,0,0,0, 0,0,1,0, "R7 no-clear data");
        step(0,0,0,0,0, 0,1,0,0, "R7 qreset keeps");
        step(0,0,0,0,0, 0,0,1,1, "R7 clear");
        step(0,0,0,0,0, 1,0,1,1, "R7 set wins");
        step(0,0,0,0,0, 0,0,1,1, "R7 clear again");
        // R8: queue reset overriding events
        for (int i = 0; i < 3; i++) step(1,0,0,0,0, 0,0,0,0, "R8 prep");
        step(0,0,1,1,1, 0,0,0,0, "R8 prep outcome");
        step(1,1,0,0,0, 0,1,0,0, "R8 reset");
        // mixed stimulus
        for (int i = 0; i < 3000; i++)
            step($urandom_range(0,1), $urandom_range(0,3) == 0, $urandom_range(0,5) == 0,
                 $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,9) == 0,
                 $urandom_range(0,60) == 0, $urandom_range(0,7) == 0, $urandom_range(0,1), "mixed");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule